// File: doc/BRIEF.md
# High-Speed External Clock Loss Monitor

This block watches an external high-speed oscillator clock for loss, using an internal reference clock that never stops. A toggle flop in the oscillator domain is brought into the reference domain through a synchronizer. A counter there measures how long it has been since the toggle last changed. When no oscillator edge has been seen for `WINDOW` reference cycles, the block declares the clock lost.

The block owns the oscillator enable bit, which software sets and clears with one-cycle pulses. Software also enables the monitor, but detection only runs while three conditions hold: the monitor is enabled, the oscillator is enabled, and the oscillator reports ready, meaning its startup delay is over. Stopping the oscillator therefore disarms the monitor at once.

On a detected loss, several things happen together. Hardware clears the oscillator enable. A one-cycle break pulse goes to three timer break inputs. A latched flag is raised for the non-maskable interrupt line. If the oscillator was feeding the system clock, a one-cycle fallback request goes to the clock selector, asking it to move to the internal divided clock.

Top module: `hse_clock_monitor`

## Requirements
- R1: After reset, `osc_en`, `brk_evt`, `nmi_flag` and `fallback_req` are all 0.
- R2: A pulse on `osc_on_set` sets `osc_en` from the next cycle, and a pulse on `osc_on_clr` clears it. When both are high together, the set wins.
- R3: No loss is ever reported while `mon_en`, `osc_en` or `osc_ready` is low. This holds however long the monitored clock stays stopped.
- R4: While the monitored clock runs with a period between 1.2 and 4 reference periods, no loss is reported.
- R5: Once the monitored clock stops while the monitor is armed, a loss is reported within `WINDOW`-4 to `WINDOW`+6 reference cycles. The report is a pulse on all three `brk_evt` bits together (value 3'b111) that lasts exactly one cycle.
- R6: `osc_en` reads 0 in the same cycle as the break pulse.
- R7: `nmi_flag` rises with the break pulse and stays high until a cycle with `irq_clr` high. A clear in the cycle a new loss is being detected has no effect.
- R8: `fallback_req` pulses together with the break pulse only if `sys_on_osc` was high at detection. Otherwise it stays 0.
- R9: After a loss, no further break pulse occurs until software sets `osc_en` again, even with `mon_en` and `osc_ready` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running internal reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset |
| mon_clk | input | 1 | Monitored external oscillator clock |
| osc_on_set | input | 1 | Software pulse: enable oscillator |
| osc_on_clr | input | 1 | Software pulse: stop oscillator |
| osc_ready | input | 1 | Oscillator startup delay has elapsed |
| mon_en | input | 1 | Software enable of the monitor |
| sys_on_osc | input | 1 | System clock currently sourced from the oscillator |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| osc_en | output | 1 | Oscillator enable |
| brk_evt | output | NUM_BRK | One-cycle failure event per timer break input |
| nmi_flag | output | 1 | Latched failure flag for the non-maskable interrupt |
| fallback_req | output | 1 | One-cycle request to fall back to the internal clock |

## Verification
Suppose the idle counter fails to reset on edges, or wraps early. A running clock then produces a false break pulse within about `WINDOW` cycles. If the counter never reaches its limit, the break pulse never appears within `WINDOW`+6 cycles of stopping the clock. A wrong arming term shows up as break pulses while the oscillator is off or not ready. A wrong flag priority shows in the one cycle where a held clear and a new detection meet: there `nmi_flag` must read 1, and it must read 0 on the next cycle.

// File: rtl/hse_clock_monitor.sv
module hse_clock_monitor #(
  parameter int WINDOW      = 8,
  parameter int NUM_BRK     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               ref_clk,
  input  logic               ref_rst_n,
  input  logic               mon_clk,
  input  logic               osc_on_set,
  input  logic               osc_on_clr,
  input  logic               osc_ready,
  input  logic               mon_en,
  input  logic               sys_on_osc,
  input  logic               irq_clr,
  output logic               osc_en,
  output logic [NUM_BRK-1:0] brk_evt,
  output logic               nmi_flag,
  output logic               fallback_req
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  logic                   mon_tog;
  logic [SYNC_STAGES:0]   sync_q;
  logic [CNT_W-1:0]       idle_cnt;

  always_ff @(posedge mon_clk or negedge ref_rst_n)
    if (!ref_rst_n) mon_tog <= 1'b0;
    else            mon_tog <= ~mon_tog;

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_STAGES-1:0], mon_tog};

  wire edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
  wire armed     = mon_en & osc_en & osc_ready;
  wire fail      = armed & ~edge_seen & (idle_cnt == LAST);

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n)                       idle_cnt <= '0;
    else if (!armed || edge_seen || fail) idle_cnt <= '0;
    else                                  idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n)      osc_en <= 1'b0;
    else if (fail)       osc_en <= 1'b0;
    else if (osc_on_set) osc_en <= 1'b1;
    else if (osc_on_clr) osc_en <= 1'b0;

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) begin
      brk_evt      <= '0;
      fallback_req <= 1'b0;
      nmi_flag     <= 1'b0;
    end else begin
      brk_evt      <= {NUM_BRK{fail}};
      fallback_req <= fail & sys_on_osc;
      nmi_flag     <= fail | (nmi_flag & ~irq_clr);
    end
endmodule

// File: rtl/hse_clock_monitor_chk.sv
module hse_clock_monitor_chk #(
  parameter int NUM_BRK = 3
) (
  input logic               ref_clk,
  input logic               ref_rst_n,
  input logic               osc_ready,
  input logic               mon_en,
  input logic               sys_on_osc,
  input logic               irq_clr,
  input logic               osc_en,
  input logic [NUM_BRK-1:0] brk_evt,
  input logic               nmi_flag,
  input logic               fallback_req
);
  p_unarmed_quiet_r3: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(mon_en && osc_en && osc_ready) |=> brk_evt == '0);

  p_brk_together_r5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (brk_evt == '0) || (brk_evt == '1));

  p_brk_one_cycle_r5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    brk_evt[0] |=> !brk_evt[0]);

  p_osc_off_r6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    brk_evt[0] |-> !osc_en);

  p_flag_set_r7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    brk_evt[0] |-> nmi_flag);

  p_flag_hold_r7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (nmi_flag && !irq_clr) |=> nmi_flag);

  p_fallback_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    brk_evt[0] |-> (fallback_req == $past(sys_on_osc)));

  p_fallback_only_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    fallback_req |-> brk_evt[0]);
endmodule

bind hse_clock_monitor hse_clock_monitor_chk #(.NUM_BRK(NUM_BRK)) u_chk (
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .osc_ready(osc_ready),
  .mon_en(mon_en), .sys_on_osc(sys_on_osc), .irq_clr(irq_clr),
  .osc_en(osc_en), .brk_evt(brk_evt), .nmi_flag(nmi_flag),
  .fallback_req(fallback_req)
);

// File: tb/hse_clock_monitor_bench.sv
`timescale 1ns/1ps
module hse_clock_monitor_bench;
  localparam int WINDOW = 8;

  logic clk = 0, rst_n = 0, mon_clk = 0;
  logic osc_on_set = 0, osc_on_clr = 0, osc_ready = 0, mon_en = 0;
  logic sys_on_osc = 0, irq_clr = 0;
  logic osc_en, nmi_flag, fallback_req;
  logic [2:0] brk_evt;

  int tests = 0, fails = 0;
  bit done = 0, mon_run = 0;
  int mon_half = 4;

  always #2.5 clk = ~clk;

  initial forever begin
    if (mon_run) begin #(mon_half); mon_clk = ~mon_clk; end
    else #1;
  end

  hse_clock_monitor #(.WINDOW(WINDOW)) u_hse_clock_monitor (
    .ref_clk(clk), .ref_rst_n(rst_n), .mon_clk(mon_clk),
    .osc_on_set(osc_on_set), .osc_on_clr(osc_on_clr), .osc_ready(osc_ready),
    .mon_en(mon_en), .sys_on_osc(sys_on_osc), .irq_clr(irq_clr),
    .osc_en(osc_en), .brk_evt(brk_evt), .nmi_flag(nmi_flag),
    .fallback_req(fallback_req));

  task automatic tick(); @(negedge clk); endtask

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit lat_ok(int lat);
    return (lat >= WINDOW - 4) && (lat <= WINDOW + 6);
  endfunction

  task automatic pulse_set();
    osc_on_set = 1; tick(); osc_on_set = 0;
  endtask

  task automatic quiet(int n, string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin tick(); if (brk_evt != 0) hits++; end
    check(hits == 0, req, hits, 0);
  endtask

  task automatic fail_round(int half, bit sys, bit hold_clr, int run_len);
    int lat = 0;
    mon_half = half; mon_run = 1; sys_on_osc = sys;
    repeat (3) tick();
    osc_ready = 1; mon_en = 1;
    pulse_set();
    check(osc_en == 1, "R2 set", osc_en, 1);
    quiet(run_len, "R4 running clock");
    irq_clr = hold_clr;
    mon_run = 0;
    while (brk_evt == 0 && lat < 40) begin tick(); lat++; end
    check(brk_evt == 3'b111, "R5 break all bits", brk_evt, 7);
    check(lat_ok(lat), "R5 latency", lat, WINDOW);
    check(osc_en == 0, "R6 osc disabled", osc_en, 0);
    check(fallback_req == sys, "R8 fallback", fallback_req, sys);
    check(nmi_flag == 1, "R7 flag set", nmi_flag, 1);
    tick();
    check(brk_evt == 0, "R5 one cycle", brk_evt, 0);
    check(fallback_req == 0, "R8 fallback one cycle", fallback_req, 0);
    if (hold_clr) begin
      check(nmi_flag == 0, "R7 clear after detect", nmi_flag, 0);
      irq_clr = 0;
    end else begin
      repeat (4) tick();
      check(nmi_flag == 1, "R7 flag held", nmi_flag, 1);
      irq_clr = 1; tick(); irq_clr = 0;
      check(nmi_flag == 0, "R7 flag cleared", nmi_flag, 0);
    end
    quiet(20, "R9 no refire");
    check(osc_en == 0, "R9 osc stays off", osc_en, 0);
    osc_ready = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    check(osc_en == 0 && brk_evt == 0 && nmi_flag == 0 && fallback_req == 0,
          "R1 reset", {osc_en, brk_evt, nmi_flag, fallback_req}, 0);
    rst_n = 1; tick();
    check(osc_en == 0 && nmi_flag == 0, "R1 after release", osc_en, 0);

    osc_on_set = 1; osc_on_clr = 1; tick(); osc_on_set = 0; osc_on_clr = 0;
    check(osc_en == 1, "R2 set wins", osc_en, 1);
    osc_on_clr = 1; tick(); osc_on_clr = 0;
    check(osc_en == 0, "R2 clear", osc_en, 0);

    mon_run = 0; osc_ready = 1; mon_en = 0; pulse_set();
    quiet(30, "R3 monitor disabled");
    mon_en = 1; osc_ready = 0;
    quiet(30, "R3 not ready");
    osc_ready = 1; osc_on_clr = 1; tick(); osc_on_clr = 0;
    quiet(30, "R3 oscillator stopped");
    check(nmi_flag == 0, "R3 no flag", nmi_flag, 0);
    mon_en = 0; osc_ready = 0;

    fail_round(3, 1'b1, 1'b0, 40);
    fail_round(10, 1'b0, 1'b1, 40);
    fail_round(3, 1'b0, 1'b0, 25);

    for (int r = 0; r < 12; r++) begin
      int h = 3 + int'($urandom_range(0, 7));
      bit s = 1'($urandom_range(0, 1));
      bit c = 1'($urandom_range(0, 1));
      fail_round(h, s, c, 20 + int'($urandom_range(0, 40)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule